// File: doc/BRIEF.md
# Vector State Register with Length Setting

This block holds the 64-bit vector-state register of a vector-capable core. It has two ways to update that register. The first is a full-register write that replaces every field at once. The second is a length-setting request. That request asks for a vector length, can also install a new maximum length, and can also install a new sub-vector group size.

Every update is checked before it commits. A requested length larger than the active maximum is clamped to that maximum. A field value that the register may not hold raises a one-cycle illegal-instruction trap, and the register keeps its old contents. The register contents and every decoded field are always visible on the outputs. A successful length-setting request also returns the length it granted, the way an instruction returns its result.

All inputs are plain strobes sampled on the rising clock edge. The block takes one request per cycle and never stalls, so no back-pressure exists. If a full write and a length-setting request arrive in the same cycle, the full write is handled and the length request is dropped.

Top module: `vsr_state`

## Requirements
- R1: After reset, the register reads 0x8000_0000_0000_0000: maximum length 64, length 0, every other field 0, which encodes a sub-vector size of 1.
- R2: Bit positions use LSB-0 numbering. Maximum length is bits 63:57, length 56:50, source step 49:43, destination step 42:36, sub-vector code 35:34, sub-step 33:32, and five 2-bit REMAP shape selectors at 31:30, 29:28, 27:26, 25:24 and 23:22. REMAP enables are bits 21:17, parallelism hint 8:2, REMAP persistence bit 1, and vertical-first bit 0. A legal full write stores these fields, and they appear on the decoded outputs.
- R3: Bits 16:9 are reserved. They always read 0, and a full write does not change them.
- R4: A legal full write whose length field is greater than its maximum-length field stores the length equal to the maximum.
- R5: A full write traps, and leaves the register unchanged, if any of these holds: maximum length is 0 or above 64; length is above 64; source step is 64 or more; destination step is 64 or more.
- R6: A length-setting request stores the smaller of the requested length and the active maximum. It then raises res_valid for one cycle, with res_vl equal to the stored length.
- R7: A length-setting request with sv_set_max puts sv_max in place as the new maximum before the clamp. An sv_max of 0, or an sv_max above 64, traps.
- R8: A length-setting request with sv_set_sub stores the count sv_sub (1 to 4) as sv_sub-1 in the 2-bit sub-vector code, and subvl_o reports the count. A count of 0, or a count of 5 to 7, traps.
- R9: A trap is a single-cycle pulse on trap_o. During a trapping request the register does not change and res_valid stays low.
- R10: When wr_en and sv_en are both high, only the full write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full-register write strobe |
| wr_data | input | 64 | Full-register write value |
| sv_en | input | 1 | Length-setting request strobe |
| sv_len | input | REQ_W | Requested vector length |
| sv_set_max | input | 1 | Also install sv_max as maximum |
| sv_max | input | REQ_W | New maximum length |
| sv_set_sub | input | 1 | Also install sv_sub as group size |
| sv_sub | input | 3 | New sub-vector count |
| state_o | output | 64 | Register contents |
| res_valid | output | 1 | Granted length is valid |
| res_vl | output | 7 | Granted length |
| trap_o | output | 1 | Illegal-instruction pulse |
| maxvl_o | output | 7 | Decoded maximum length |
| vl_o | output | 7 | Decoded length |
| srcstep_o | output | 7 | Decoded source step |
| dststep_o | output | 7 | Decoded destination step |
| subvl_o | output | 3 | Sub-vector count, 1 to 4 |
| substep_o | output | 2 | Decoded sub-step |
| remap_en_o | output | 5 | REMAP enables |
| remap_sel_o | output | 10 | Five shape selectors, first at MSBs |
| hint_o | output | 7 | Parallelism hint |
| remap_keep_o | output | 1 | REMAP persistence |
| vfirst_o | output | 1 | Vertical-first mode |

## Verification
Every result is due exactly one cycle after the edge that samples the request. The register, its decoded fields, res_valid, res_vl and trap_o all come from the same single flop stage, and the decode adds no further delay. The bench drives each request on a falling edge and lets one rising edge pass. On the next falling edge it compares every output against a behavioural model that was advanced on that same rising edge. Idle cycles are compared the same way, so a pulse that lasts too long or a stray write is seen at once.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int LEN_W = 7;
  localparam int SEL_W = 2;
  localparam int NSEL  = 5;

  // Member order follows the register's MSB-first layout
  typedef struct packed {
    logic [LEN_W-1:0] maxvl;
    logic [LEN_W-1:0] vl;
    logic [LEN_W-1:0] srcstep;
    logic [LEN_W-1:0] dststep;
    logic [1:0]       subcode;
    logic [1:0]       substep;
    logic [NSEL-1:0][SEL_W-1:0] sel;
    logic [NSEL-1:0]  remap_en;
    logic [7:0]       rsvd;
    logic [LEN_W-1:0] hint;
    logic             remap_keep;
    logic             vfirst;
  } vstate_t;
endpackage

// File: rtl/vsr_wr_check.sv
module vsr_wr_check
  import vsr_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic [63:0] wr_data,
  output logic        ok,
  output vstate_t     fixed
);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_LEN);

  vstate_t raw;

  always_comb begin
    raw = vstate_t'(wr_data);
    ok  = (raw.maxvl != '0) && (raw.maxvl <= LIM) && (raw.vl <= LIM)
          && (raw.srcstep < LIM) && (raw.dststep < LIM);
    fixed      = raw;
    fixed.rsvd = '0;
    if (raw.vl > raw.maxvl) fixed.vl = raw.maxvl;
  end
endmodule

// File: rtl/vsr_setvl_unit.sv
module vsr_setvl_unit
  import vsr_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 16
) (
  input  vstate_t          cur,
  input  logic [REQ_W-1:0] req_len,
  input  logic             set_max,
  input  logic [REQ_W-1:0] new_max,
  input  logic             set_sub,
  input  logic [2:0]       sub_cnt,
  output logic             ok,
  output vstate_t          nxt,
  output logic [LEN_W-1:0] granted
);
  localparam logic [REQ_W-1:0] LIM = REQ_W'(MAX_LEN);

  logic             max_ok;
  logic             sub_ok;
  logic [LEN_W-1:0] eff_max;

  always_comb begin
    max_ok  = !set_max || ((new_max != '0) && (new_max <= LIM));
    sub_ok  = !set_sub || ((sub_cnt >= 3'd1) && (sub_cnt <= 3'd4));
    ok      = max_ok && sub_ok;
    eff_max = set_max ? new_max[LEN_W-1:0] : cur.maxvl;
    if (req_len < REQ_W'(eff_max)) granted = req_len[LEN_W-1:0];
    else                           granted = eff_max;
    nxt       = cur;
    nxt.maxvl = eff_max;
    nxt.vl    = granted;
    if (set_sub) nxt.subcode = 2'(sub_cnt - 3'd1);
  end
endmodule

// File: rtl/vsr_field_decode.sv
module vsr_field_decode
  import vsr_pkg::*;
(
  input  vstate_t                st,
  output logic [LEN_W-1:0]       maxvl_o,
  output logic [LEN_W-1:0]       vl_o,
  output logic [LEN_W-1:0]       srcstep_o,
  output logic [LEN_W-1:0]       dststep_o,
  output logic [2:0]             subvl_o,
  output logic [1:0]             substep_o,
  output logic [NSEL-1:0]        remap_en_o,
  output logic [NSEL*SEL_W-1:0]  remap_sel_o,
  output logic [LEN_W-1:0]       hint_o,
  output logic                   remap_keep_o,
  output logic                   vfirst_o
);
  assign maxvl_o      = st.maxvl;
  assign vl_o         = st.vl;
  assign srcstep_o    = st.srcstep;
  assign dststep_o    = st.dststep;
  assign subvl_o      = {1'b0, st.subcode} + 3'd1;
  assign substep_o    = st.substep;
  assign remap_en_o   = st.remap_en;
  assign hint_o       = st.hint;
  assign remap_keep_o = st.remap_keep;
  assign vfirst_o     = st.vfirst;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign remap_sel_o[i*SEL_W +: SEL_W] = st.sel[i];
  end
endmodule

// File: rtl/vsr_state.sv
module vsr_state
  import vsr_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 16,
  parameter int RST_MAX = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [63:0]           wr_data,
  input  logic                  sv_en,
  input  logic [REQ_W-1:0]      sv_len,
  input  logic                  sv_set_max,
  input  logic [REQ_W-1:0]      sv_max,
  input  logic                  sv_set_sub,
  input  logic [2:0]            sv_sub,
  output logic [63:0]           state_o,
  output logic                  res_valid,
  output logic [LEN_W-1:0]      res_vl,
  output logic                  trap_o,
  output logic [LEN_W-1:0]      maxvl_o,
  output logic [LEN_W-1:0]      vl_o,
  output logic [LEN_W-1:0]      srcstep_o,
  output logic [LEN_W-1:0]      dststep_o,
  output logic [2:0]            subvl_o,
  output logic [1:0]            substep_o,
  output logic [NSEL-1:0]       remap_en_o,
  output logic [NSEL*SEL_W-1:0] remap_sel_o,
  output logic [LEN_W-1:0]      hint_o,
  output logic                  remap_keep_o,
  output logic                  vfirst_o
);
  vstate_t          st;
  logic             wr_ok;
  vstate_t          wr_fixed;
  logic             sv_ok;
  vstate_t          sv_nxt;
  logic [LEN_W-1:0] sv_granted;

  vsr_wr_check #(.MAX_LEN(MAX_LEN)) u_wr (
    .wr_data (wr_data),
    .ok      (wr_ok),
    .fixed   (wr_fixed)
  );

  vsr_setvl_unit #(.MAX_LEN(MAX_LEN), .REQ_W(REQ_W)) u_sv (
    .cur     (st),
    .req_len (sv_len),
    .set_max (sv_set_max),
    .new_max (sv_max),
    .set_sub (sv_set_sub),
    .sub_cnt (sv_sub),
    .ok      (sv_ok),
    .nxt     (sv_nxt),
    .granted (sv_granted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= '0;
      st.maxvl  <= LEN_W'(RST_MAX);
      trap_o    <= 1'b0;
      res_valid <= 1'b0;
      res_vl    <= '0;
    end else begin
      trap_o    <= 1'b0;
      res_valid <= 1'b0;
      if (wr_en) begin
        if (wr_ok) st <= wr_fixed;
        else       trap_o <= 1'b1;
      end else if (sv_en) begin
        if (sv_ok) begin
          st        <= sv_nxt;
          res_valid <= 1'b1;
          res_vl    <= sv_granted;
        end else begin
          trap_o <= 1'b1;
        end
      end
    end
  end

  assign state_o = st;

  vsr_field_decode u_dec (
    .st           (st),
    .maxvl_o      (maxvl_o),
    .vl_o         (vl_o),
    .srcstep_o    (srcstep_o),
    .dststep_o    (dststep_o),
    .subvl_o      (subvl_o),
    .substep_o    (substep_o),
    .remap_en_o   (remap_en_o),
    .remap_sel_o  (remap_sel_o),
    .hint_o       (hint_o),
    .remap_keep_o (remap_keep_o),
    .vfirst_o     (vfirst_o)
  );
endmodule

// File: rtl/vsr_state_chk.sv
module vsr_state_chk #(
  parameter int MAX_LEN = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] state_o,
  input logic        trap_o,
  input logic        res_valid,
  input logic [6:0]  res_vl
);
  // R9: a trapping request leaves the register as it was
  assert_trap_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $stable(state_o));

  // R3: reserved bits never become non-zero
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[16:9] == 8'd0);

  // R4: stored length never exceeds stored maximum
  assert_vl_le_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[56:50] <= state_o[63:57]);

  // R7: stored maximum stays in its legal range
  assert_max_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[63:57] != 7'd0) && (state_o[63:57] <= 7'(MAX_LEN)));

  // R5: stored steps stay below the limit
  assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[49:43] < 7'(MAX_LEN)) && (state_o[42:36] < 7'(MAX_LEN)));

  // R6: returned length matches the stored length
  assert_result_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_vl == state_o[56:50]));

  // R9: trap and result never together
  assert_trap_no_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_o && res_valid));
endmodule

bind vsr_state vsr_state_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state_o   (state_o),
  .trap_o    (trap_o),
  .res_valid (res_valid),
  .res_vl    (res_vl)
);

// File: tb/sim_vsr_state.sv
module sim_vsr_state;
  localparam int CLK_PERIOD = 10;
  localparam int REQ_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [63:0]      wr_data = '0;
  logic             sv_en = 1'b0;
  logic [REQ_W-1:0] sv_len = '0;
  logic             sv_set_max = 1'b0;
  logic [REQ_W-1:0] sv_max = '0;
  logic             sv_set_sub = 1'b0;
  logic [2:0]       sv_sub = '0;

  logic [63:0] state_o;
  logic        res_valid, trap_o, remap_keep_o, vfirst_o;
  logic [6:0]  res_vl, maxvl_o, vl_o, srcstep_o, dststep_o, hint_o;
  logic [2:0]  subvl_o;
  logic [1:0]  substep_o;
  logic [4:0]  remap_en_o;
  logic [9:0]  remap_sel_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsr_state #(.REQ_W(REQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sv_en(sv_en), .sv_len(sv_len), .sv_set_max(sv_set_max), .sv_max(sv_max),
    .sv_set_sub(sv_set_sub), .sv_sub(sv_sub),
    .state_o(state_o), .res_valid(res_valid), .res_vl(res_vl), .trap_o(trap_o),
    .maxvl_o(maxvl_o), .vl_o(vl_o), .srcstep_o(srcstep_o), .dststep_o(dststep_o),
    .subvl_o(subvl_o), .substep_o(substep_o), .remap_en_o(remap_en_o),
    .remap_sel_o(remap_sel_o), .hint_o(hint_o), .remap_keep_o(remap_keep_o),
    .vfirst_o(vfirst_o)
  );

  // Behavioural reference model, advanced on every rising edge
  logic [63:0] m_st;
  logic        m_trap, m_rv;
  logic [6:0]  m_rvl;

  always @(posedge clk) begin
    int mx, v, ss, ds, rq;
    bit bad;
    if (!rst_n) begin
      m_st = 64'h8000_0000_0000_0000; m_trap = 0; m_rv = 0; m_rvl = 0;
    end else begin
      m_trap = 0; m_rv = 0;
      if (wr_en) begin
        mx = wr_data[63:57]; v = wr_data[56:50];
        ss = wr_data[49:43]; ds = wr_data[42:36];
        bad = (mx == 0) || (mx > 64) || (v > 64) || (ss >= 64) || (ds >= 64);
        if (bad) m_trap = 1;
        else begin
          m_st = wr_data;
          m_st[16:9] = 8'd0;
          if (v > mx) m_st[56:50] = 7'(mx);
        end
      end else if (sv_en) begin
        bad = (sv_set_max && (sv_max == 0 || sv_max > 64)) ||
              (sv_set_sub && (sv_sub < 1 || sv_sub > 4));
        if (bad) m_trap = 1;
        else begin
          mx = sv_set_max ? int'(sv_max) : int'(m_st[63:57]);
          rq = sv_len;
          v  = (rq < mx) ? rq : mx;
          m_st[63:57] = 7'(mx);
          m_st[56:50] = 7'(v);
          if (sv_set_sub) m_st[35:34] = 2'(sv_sub - 1);
          m_rv = 1; m_rvl = 7'(v);
        end
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    chk(tag, "state", state_o, m_st);
    chk(tag, "trap", 64'(trap_o), 64'(m_trap));
    chk(tag, "res_valid", 64'(res_valid), 64'(m_rv));
    if (m_rv) chk(tag, "res_vl", 64'(res_vl), 64'(m_rvl));
    chk(tag, "maxvl", 64'(maxvl_o), 64'(m_st[63:57]));
    chk(tag, "vl", 64'(vl_o), 64'(m_st[56:50]));
    chk(tag, "srcstep", 64'(srcstep_o), 64'(m_st[49:43]));
    chk(tag, "dststep", 64'(dststep_o), 64'(m_st[42:36]));
    chk(tag, "subvl", 64'(subvl_o), 64'(m_st[35:34]) + 64'd1);
    chk(tag, "substep", 64'(substep_o), 64'(m_st[33:32]));
    chk(tag, "remap_sel", 64'(remap_sel_o), 64'(m_st[31:22]));
    chk(tag, "remap_en", 64'(remap_en_o), 64'(m_st[21:17]));
    chk(tag, "hint", 64'(hint_o), 64'(m_st[8:2]));
    chk(tag, "keep", 64'(remap_keep_o), 64'(m_st[1]));
    chk(tag, "vfirst", 64'(vfirst_o), 64'(m_st[0]));
  endtask

  task automatic clear_in();
    wr_en = 0; sv_en = 0; sv_set_max = 0; sv_set_sub = 0;
  endtask

  task automatic settle(string tag);
    @(negedge clk);
    clear_in();
    cmp(tag);
  endtask

  task automatic do_wr(string tag, logic [63:0] d);
    wr_en = 1; wr_data = d;
    settle(tag);
  endtask

  task automatic do_sv(string tag, int len, bit sm, int mx, bit ssub, int sub);
    sv_en = 1; sv_len = REQ_W'(len); sv_set_max = sm; sv_max = REQ_W'(mx);
    sv_set_sub = ssub; sv_sub = 3'(sub);
    settle(tag);
  endtask

  function automatic logic [63:0] pk(int mx, int v, int ss, int ds);
    return {7'(mx), 7'(v), 7'(ss), 7'(ds), 36'd0};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset state", state_o, 64'h8000_0000_0000_0000);
    cmp("R1");

    // R2 R3: every field at its position, reserved bits written as ones
    do_wr("R2_R3", {7'd40, 7'd10, 7'd5, 7'd7, 2'd2, 2'd1, 2'd3, 2'd0, 2'd1,
                    2'd2, 2'd3, 5'b10101, 8'hFF, 7'd9, 1'b1, 1'b1});
    chk("R3", "reserved", 64'(state_o[16:9]), 64'd0);
    do_wr("R2", {7'd3, 7'd1, 7'd2, 7'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd2,
                 2'd1, 2'd0, 5'b01010, 8'h00, 7'd77, 1'b0, 1'b0});
    do_wr("R4", pk(20, 50, 0, 0));
    chk("R4", "clamped vl", 64'(vl_o), 64'd20);
    do_wr("R5", pk(64, 64, 63, 63));
    do_wr("R5", pk(64, 65, 0, 0));
    chk("R5", "trap vl>64", 64'(trap_o), 64'd1);
    do_wr("R5", pk(0, 0, 0, 0));
    do_wr("R5", pk(65, 3, 0, 0));
    do_wr("R5", pk(30, 3, 64, 0));
    do_wr("R5", pk(30, 3, 0, 64));
    chk("R5", "state after trap", 64'(maxvl_o), 64'd64);
    settle("R9");
    chk("R9", "trap pulse ends", 64'(trap_o), 64'd0);

    do_sv("R6", 1000, 0, 0, 0, 0);
    chk("R6", "vl=max", 64'(res_vl), 64'd64);
    do_sv("R6", 3, 0, 0, 0, 0);
    do_sv("R6", 0, 0, 0, 0, 0);
    do_sv("R7", 30, 1, 16, 0, 0);
    chk("R7", "vl clamped to new max", 64'(vl_o), 64'd16);
    do_sv("R7", 5, 1, 0, 0, 0);
    do_sv("R7", 5, 1, 65, 0, 0);
    do_sv("R7", 64, 1, 64, 0, 0);
    do_sv("R7", 2, 1, 1, 0, 0);
    for (int s = 1; s <= 4; s++) begin
      do_sv("R8", 7, 1, 32, 1, s);
      chk("R8", "subvl count", 64'(subvl_o), 64'(s));
    end
    do_sv("R8", 7, 0, 0, 1, 0);
    do_sv("R8", 7, 0, 0, 1, 5);
    do_sv("R8", 7, 0, 0, 1, 7);
    chk("R9", "no result on trap", 64'(res_valid), 64'd0);

    // R10: both requests in one cycle, write wins
    wr_en = 1; wr_data = pk(12, 4, 1, 2);
    sv_en = 1; sv_len = 50; sv_set_max = 1; sv_max = 40;
    settle("R10");
    chk("R10", "max from write", 64'(maxvl_o), 64'd12);
    chk("R10", "no setvl result", 64'(res_valid), 64'd0);
    wr_en = 1; wr_data = pk(0, 0, 0, 0); sv_en = 1; sv_len = 5;
    settle("R10");
    repeat (3) settle("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule